// File: doc/BRIEF.md
# Transfer Length Command Encoder

This block turns one transfer request into the short run of command entries that a serial flash engine downstream consumes. A request carries a byte count of up to 2^20 and a small template of command bits (data-transfer enable, lane mode, chip select, bus select and direction). The block answers with one or more command entries, one per cycle, over a valid/ready output.

A short count goes out as a single immediate entry that holds the count itself. A long count is split up. The low byte is set aside. Each set bit k of the upper part becomes one exponent entry whose immediate field holds k, so that entry stands for 2^k bytes. After the exponent entries comes one immediate entry for the low byte, but only when that byte is non-zero. As an option, an all-zero no-op entry can be appended to close the run, as a receive done without DMA needs.

A request is taken only while the block is idle. The final entry of each run carries a last flag.

Top module: `lce_encoder`

## Requirements
- R1: A count below 255 yields exactly one entry with the exponent flag (entry bit 8) clear and the count in entry bits 7:0.
- R2: For a count of 255 or more, every set bit at position k (k >= 8) of the count yields one entry with the exponent flag set and k in bits 7:0. No other exponent entries are produced.
- R3: Exponent entries leave in strictly ascending order of k.
- R4: After the exponent entries, an entry with the exponent flag clear and the low count byte in bits 7:0 follows only when that byte is non-zero.
- R5: Every length entry carries the request template unchanged in entry bits 17:9 (bit 9 data-transfer, bits 11:10 mode, bits 13:12 chip select, bits 15:14 bus, bit 16 transmit, bit 17 receive).
- R6: When the request's pad input is set, one all-zero entry is emitted after the length entries.
- R7: `req_ready` is high only while no entry is pending. A request presented while busy is ignored and does not change the entries being emitted.
- R8: While `out_valid` is high and `out_ready` is low, `out_entry` and `out_last` hold their values.
- R9: A count of exactly 255 yields a single entry with the exponent flag clear and immediate 255.
- R10: `out_last` is high on the final entry of a run and low on every other entry. After that entry is accepted, `out_valid` drops.
- R11: After reset, `out_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken |
| req_count | input | 21 | Transfer byte count |
| req_tmpl | input | 9 | Command template bits |
| req_pad | input | 1 | Append no-op entry |
| out_valid | output | 1 | Entry present |
| out_ready | input | 1 | Consumer takes entry |
| out_entry | output | 18 | Command entry |
| out_last | output | 1 | Final entry of the run |

## Verification
Directed counts probe the split between the two paths. The count 254 shows the short path, and 255 shows the one-entry result of the long path. The count 256 gives an exponent entry with no remainder, 257 gives one with a remainder, and 2^20 and 0xFFF00 give a lone top bit and many bits with a zero low byte. Random counts with random templates and pad choices, under random output stalls, show whether decomposition, ordering, template copying and hold-under-stall agree with a bench model. Requests pushed at the block while it is busy show whether a run can be disturbed.

// File: rtl/lce_pkg.sv
package lce_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_EXP  = 2'd1,
      ST_LOW  = 2'd2,
      ST_PAD  = 2'd3
   } lce_state_e;
endpackage

// File: rtl/lce_lowbit.sv
// Lowest-set-bit finder over a vector of W bits.
module lce_lowbit #(
   parameter int W     = 13,
   localparam int IDX_W = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]     vec,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec[i]) idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/lce_pack.sv
// Assembles one command entry: {template, exponent flag, immediate}.
module lce_pack #(
   parameter int TMPL_W = 9,
   parameter int IMM_W  = 8,
   localparam int ENT_W = TMPL_W + 1 + IMM_W
) (
   input  logic [TMPL_W-1:0] tmpl,
   input  logic              is_exp,
   input  logic [IMM_W-1:0]  imm,
   input  logic              blank,
   output logic [ENT_W-1:0]  entry
);
   always_comb begin
      if (blank) entry = '0;
      else       entry = {tmpl, is_exp, imm};
   end
endmodule

// File: rtl/lce_encoder.sv
module lce_encoder
   import lce_pkg::*;
#(
   parameter int CNT_W  = 21,
   parameter int TMPL_W = 9,
   parameter int IMM_W  = 8,
   parameter bit PAD_EN = 1'b1,
   localparam int ENT_W = TMPL_W + 1 + IMM_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [CNT_W-1:0]  req_count,
   input  logic [TMPL_W-1:0] req_tmpl,
   input  logic              req_pad,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [ENT_W-1:0]  out_entry,
   output logic              out_last
);
   localparam int HI_W  = CNT_W - IMM_W;
   localparam int IDX_W = (HI_W > 1) ? $clog2(HI_W) : 1;

   // elaboration-time parameter checks
   if (HI_W < 1) begin : g_bad_cnt
      $error("CNT_W must exceed IMM_W");
   end
   if (CNT_W - 1 >= (1 << IMM_W)) begin : g_bad_imm
      $error("IMM_W too narrow to hold an exponent");
   end
   if (TMPL_W < 1) begin : g_bad_tmpl
      $error("TMPL_W must be positive");
   end

   lce_state_e        st_q;
   logic [HI_W-1:0]   hi_q;
   logic [IMM_W-1:0]  lo_q;
   logic [TMPL_W-1:0] tmpl_q;
   logic              pad_q;
   logic              pad_in;

   if (PAD_EN) begin : g_pad
      assign pad_in = req_pad;
   end else begin : g_nopad
      logic unused_pad;
      assign unused_pad = req_pad;
      assign pad_in     = 1'b0;
   end

   logic [HI_W-1:0]  hi_in;
   logic [HI_W-1:0]  hi_next;
   logic [IDX_W-1:0] bit_idx;
   logic             last_exp;
   logic             accept;
   logic             take;
   lce_state_e       after_len;

   assign hi_in     = req_count[CNT_W-1:IMM_W];
   assign req_ready = (st_q == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign out_valid = (st_q != ST_IDLE);
   assign take      = out_valid && out_ready;
   assign hi_next   = hi_q & (hi_q - HI_W'(1));
   assign last_exp  = (hi_next == '0);
   assign after_len = pad_q ? ST_PAD : ST_IDLE;

   lce_lowbit #(.W(HI_W)) u_lowbit (
      .vec (hi_q),
      .idx (bit_idx)
   );

   logic             ent_exp;
   logic [IMM_W-1:0] ent_imm;
   logic             ent_blank;

   always_comb begin
      ent_exp   = (st_q == ST_EXP);
      ent_blank = (st_q == ST_PAD) || (st_q == ST_IDLE);
      if (st_q == ST_EXP) ent_imm = IMM_W'(bit_idx) + IMM_W'(IMM_W);
      else                ent_imm = lo_q;
   end

   lce_pack #(.TMPL_W(TMPL_W), .IMM_W(IMM_W)) u_pack (
      .tmpl   (tmpl_q),
      .is_exp (ent_exp),
      .imm    (ent_imm),
      .blank  (ent_blank),
      .entry  (out_entry)
   );

   always_comb begin
      unique case (st_q)
         ST_EXP:  out_last = last_exp && (lo_q == '0) && !pad_q;
         ST_LOW:  out_last = !pad_q;
         ST_PAD:  out_last = 1'b1;
         default: out_last = 1'b0;
      endcase
   end

   // A count with an empty upper part (below 255, or exactly 255) needs only
   // the immediate entry; any upper bit sends the run through exponents.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         hi_q   <= '0;
         lo_q   <= '0;
         tmpl_q <= '0;
         pad_q  <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (accept) begin
               hi_q   <= hi_in;
               lo_q   <= req_count[IMM_W-1:0];
               tmpl_q <= req_tmpl;
               pad_q  <= pad_in;
               st_q   <= (hi_in != '0) ? ST_EXP : ST_LOW;
            end
            ST_EXP: if (take) begin
               hi_q <= hi_next;
               if (last_exp) st_q <= (lo_q != '0) ? ST_LOW : after_len;
            end
            ST_LOW: if (take) st_q <= after_len;
            ST_PAD: if (take) st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // R8
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_entry) && $stable(out_last)));

   // R7
   busy_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !req_ready);

   // R3
   exp_ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_entry[IMM_W] && $past(take && out_entry[IMM_W]))
      |-> (out_entry[IMM_W-1:0] > $past(out_entry[IMM_W-1:0])));

   // R2
   exp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_entry[IMM_W]) |->
      ((out_entry[IMM_W-1:0] >= IMM_W'(IMM_W)) && (out_entry[IMM_W-1:0] < IMM_W'(CNT_W))));

   // R1
   short_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && (hi_in == '0)) |=>
      (out_valid && !out_entry[IMM_W] && (out_entry[IMM_W-1:0] == $past(req_count[IMM_W-1:0]))));
endmodule

// File: tb/lce_encoder_tb.sv
`timescale 1ns/1ps
module lce_encoder_tb_top;
   localparam int CW = 21;
   localparam int TW = 9;
   localparam int IW = 8;
   localparam int EW = TW + 1 + IW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [CW-1:0] req_count = '0;
   logic [TW-1:0] req_tmpl = '0;
   logic          req_pad = 1'b0;
   logic          out_valid;
   logic          out_ready = 1'b0;
   logic [EW-1:0] out_entry;
   logic          out_last;

   always #2.5 clk = ~clk;

   lce_encoder dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_count(req_count), .req_tmpl(req_tmpl), .req_pad(req_pad),
      .out_valid(out_valid), .out_ready(out_ready), .out_entry(out_entry),
      .out_last(out_last)
   );

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   logic [EW-1:0] exp_q[$];
   string         tag_q[$];

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [EW-1:0] act,
                      input logic [EW-1:0] expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, expv);
      end
   endtask

   // Bench model of the entry run built from the requirements.
   task automatic build(input int cnt, input logic [TW-1:0] t, input bit pad);
      exp_q.delete();
      tag_q.delete();
      if (cnt < 255) begin
         exp_q.push_back({t, 1'b0, IW'(cnt)});
         tag_q.push_back("R1 R5");
      end else begin
         for (int k = 8; k < CW; k++) begin
            if (cnt[k]) begin
               exp_q.push_back({t, 1'b1, IW'(k)});
               tag_q.push_back("R2 R3 R5");
            end
         end
         if (cnt[7:0] != 0) begin
            exp_q.push_back({t, 1'b0, cnt[7:0]});
            tag_q.push_back(cnt == 255 ? "R9" : "R4 R5");
         end
      end
      if (pad) begin
         exp_q.push_back('0);
         tag_q.push_back("R6");
      end
   endtask

   task automatic run_req(input int cnt, input logic [TW-1:0] t, input bit pad,
                          input int stall_pct);
      logic [EW-1:0] held_d;
      bit            held_l;
      bit            held = 0;
      bit            done = 0;
      int            guard = 0;
      build(cnt, t, pad);
      @(negedge clk);
      req_valid = 1'b1;
      req_count = CW'(cnt);
      req_tmpl  = t;
      req_pad   = pad;
      @(negedge clk);
      req_valid = 1'b0;
      while (!done && guard < 2000) begin
         guard++;
         if (!out_valid) begin
            chk(0, "R10", {17'b0, out_valid}, 1);
            done = 1;
         end else begin
            if (held) begin
               chk(out_entry == held_d && out_last == held_l, "R8", out_entry, held_d);
            end
            // R7: busy, so a new request must be refused
            chk(!req_ready, "R7", {17'b0, req_ready}, 0);
            if (!out_last) begin
               req_valid = 1'b1;
               req_count = CW'($urandom);
               req_tmpl  = TW'($urandom);
               req_pad   = 1'($urandom);
            end else begin
               req_valid = 1'b0;
            end
            out_ready = (($urandom % 100) >= stall_pct);
            if (out_ready) begin
               held = 0;
               if (exp_q.size() == 0) begin
                  chk(0, "R10", out_entry, '0);
                  done = 1;
               end else begin
                  logic [EW-1:0] e;
                  string tg;
                  e  = exp_q.pop_front();
                  tg = tag_q.pop_front();
                  chk(out_entry == e, tg, out_entry, e);
                  chk(out_last == (exp_q.size() == 0), "R10", {17'b0, out_last},
                      {17'b0, exp_q.size() == 0});
                  if (exp_q.size() == 0) done = 1;
               end
            end else begin
               held   = 1;
               held_d = out_entry;
               held_l = out_last;
            end
         end
         @(negedge clk);
      end
      req_valid = 1'b0;
      out_ready = 1'b0;
      // R10: run finished, nothing further pending
      chk(!out_valid && req_ready, "R10", {16'b0, out_valid, req_ready}, 18'd1);
      chk(exp_q.size() == 0, "R2", EW'(exp_q.size()), '0);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R11: reset state
      chk(!out_valid && req_ready, "R11", {16'b0, out_valid, req_ready}, 18'd1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!out_valid && req_ready, "R11", {16'b0, out_valid, req_ready}, 18'd1);
      run_req(0,        9'h155, 0, 0);
      run_req(1,        9'h0AA, 1, 30);
      run_req(254,      9'h1FF, 0, 50);
      run_req(255,      9'h101, 0, 0);
      run_req(255,      9'h101, 1, 40);
      run_req(256,      9'h033, 0, 20);
      run_req(257,      9'h0F0, 1, 20);
      run_req(511,      9'h10F, 0, 60);
      run_req(1 << 20,  9'h1C3, 0, 30);
      run_req(32'hFFF00, 9'h07E, 1, 50);
      run_req(32'hFFFFF, 9'h12D, 0, 10);
      for (int n = 0; n < 200; n++) begin
         int c;
         if (($urandom % 3) == 0) c = $urandom % 300;
         else                     c = $urandom % ((1 << 20) + 1);
         run_req(c, TW'($urandom), 1'($urandom), $urandom % 70);
      end
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule